// File: doc/BRIEF.md
# Bitmap pattern-address remapper

This block sits between the picture processor's address bus and an 8 KiB character RAM. It normally passes the low thirteen address bits straight through. When bitmap mode is enabled, it changes two of those bits during pattern-table reads, so that one 8 KiB RAM can hold a whole all-points-addressable screen. In a pattern read, bit 3 of the RAM address comes from PPU address bit 0 and bit 12 comes from PPU address bit 9.

Those two source bits are not taken from the live pattern address. They are captured when PPU address bit 13 goes from 0 to 1, which happens at the start of each name-table fetch. They are held until the next such transition. The block runs in a clock domain that oversamples the PPU bus. The address and the enable are registered on entry, the transition is detected between consecutive samples, and the RAM address leaves through an output register.

Top module: `chr_bitmap_remap`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `chr_addr` is 0.
- R2: With `bitmap_en` sampled as 0, `chr_addr` equals bits 12..0 of the sampled `ppu_addr`.
- R3: For a sample with `ppu_addr` bit 13 at 1 (name-table access), `chr_addr` equals bits 12..0 of that sample, whatever the enable is.
- R4: For a sample with `bitmap_en` at 1 and `ppu_addr` bit 13 at 0, `chr_addr` bit 3 equals the captured copy of PPU bit 0, and `chr_addr` bit 12 equals the captured copy of PPU bit 9.
- R5: The captured pair loads bits 0 and 9 from the first sample in which bit 13 is 1 after a sample in which it was 0. It holds through every other sample, including samples where bit 13 stays at 1 and the address changes.
- R6: `chr_addr` bits 2..0 and 11..4 always equal the same bits of the sampled address.
- R7: The captured pair is 0 after reset. With bitmap mode on and no name-table access yet, `chr_addr` bits 3 and 12 read 0.
- R8: Inputs are sampled on one rising clock edge, and the result appears on `chr_addr` after the next rising edge.
- R9: The enable is sampled together with the address. A change of the enable takes effect from the access presented with it.
- R10: The captured pair updates on a bit-13 rise even when bitmap mode is off. It updates once per rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling clock |
| rst | input | 1 | Synchronous active-high reset |
| ppu_addr | input | 14 | PPU address bus, bit 13 selects name-table space |
| bitmap_en | input | 1 | Bitmap mode enable from the mapper register |
| chr_addr | output | 13 | Character RAM address |

## Verification
Two events can meet in one cycle. The first is a bit-13 rise that loads the captured pair while a remapped pattern read is being formed. The bench provokes this with a name-table sample that lasts a single cycle and is followed at once by a pattern read. The pattern read must then see the newly captured bits, not the old ones. The second is an enable change presented together with a fresh address. The bench toggles the enable on consecutive cycles and checks that each result follows the enable that came with its own address. A behavioural reference model is compared with `chr_addr` on every clock.

// File: rtl/chr_remap_pkg.sv
package chr_remap_pkg;

  typedef struct packed {
    logic hi;
    logic lo;
  } cap_pair_t;

  localparam int DEF_PPU_W = 14;

endpackage

// File: rtl/ppu_bus_sampler.sv
module ppu_bus_sampler #(
  parameter int PPU_W   = 14,
  parameter int SPACE_B = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PPU_W-1:0] addr_in,
  input  logic             en_in,
  output logic [PPU_W-1:0] addr_q,
  output logic             en_q,
  output logic             space_rise
);

  logic space_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q     <= '0;
      en_q       <= 1'b0;
      space_prev <= 1'b0;
    end else begin
      addr_q     <= addr_in;
      en_q       <= en_in;
      space_prev <= addr_q[SPACE_B];
    end
  end

  // A rise is seen between two consecutive registered samples
  always_comb space_rise = addr_q[SPACE_B] & ~space_prev;

endmodule

// File: rtl/fetch_tag_latch.sv
module fetch_tag_latch
  import chr_remap_pkg::*;
#(
  parameter int PPU_W  = 14,
  parameter int SRC_LO = 0,
  parameter int SRC_HI = 9
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PPU_W-1:0] addr_q,
  output cap_pair_t        cap
);

  always_ff @(posedge clk) begin
    if (rst) begin
      cap <= '0;
    end else if (load) begin
      cap.lo <= addr_q[SRC_LO];
      cap.hi <= addr_q[SRC_HI];
    end
  end

endmodule

// File: rtl/chr_addr_former.sv
module chr_addr_former
  import chr_remap_pkg::*;
#(
  parameter int PPU_W   = 14,
  parameter int SPACE_B = 13,
  parameter int DST_LO  = 3,
  parameter int DST_HI  = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PPU_W-1:0] addr_q,
  input  logic             en_q,
  input  cap_pair_t        cap,
  output logic [PPU_W-2:0] chr_q
);

  localparam int CHR_W = PPU_W - 1;

  logic             remap;
  logic [CHR_W-1:0] chr_d;

  always_comb remap = en_q & ~addr_q[SPACE_B];

  for (genvar i = 0; i < CHR_W; i++) begin : g_bit
    if (i == DST_LO) begin : g_lo
      always_comb chr_d[i] = remap ? cap.lo : addr_q[i];
    end else if (i == DST_HI) begin : g_hi
      always_comb chr_d[i] = remap ? cap.hi : addr_q[i];
    end else begin : g_pass
      always_comb chr_d[i] = addr_q[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) chr_q <= '0;
    else     chr_q <= chr_d;
  end

endmodule

// File: rtl/chr_bitmap_remap.sv
module chr_bitmap_remap
  import chr_remap_pkg::*;
#(
  parameter int PPU_W  = DEF_PPU_W,
  parameter int SRC_LO = 0,
  parameter int SRC_HI = 9,
  parameter int DST_LO = 3,
  parameter int DST_HI = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [PPU_W-1:0] ppu_addr,
  input  logic             bitmap_en,
  output logic [PPU_W-2:0] chr_addr
);

  localparam int SPACE_B = PPU_W - 1;

  logic [PPU_W-1:0] samp_addr;
  logic             samp_en;
  logic             a13_rise;
  cap_pair_t        cap;
  logic             lat_lo;
  logic             lat_hi;

  ppu_bus_sampler #(.PPU_W(PPU_W), .SPACE_B(SPACE_B)) u_samp (
    .clk(clk), .rst(rst), .addr_in(ppu_addr), .en_in(bitmap_en),
    .addr_q(samp_addr), .en_q(samp_en), .space_rise(a13_rise)
  );

  fetch_tag_latch #(.PPU_W(PPU_W), .SRC_LO(SRC_LO), .SRC_HI(SRC_HI)) u_tag (
    .clk(clk), .rst(rst), .load(a13_rise), .addr_q(samp_addr), .cap(cap)
  );

  always_comb begin
    lat_lo = cap.lo;
    lat_hi = cap.hi;
  end

  chr_addr_former #(.PPU_W(PPU_W), .SPACE_B(SPACE_B),
                    .DST_LO(DST_LO), .DST_HI(DST_HI)) u_form (
    .clk(clk), .rst(rst), .addr_q(samp_addr), .en_q(samp_en),
    .cap(cap), .chr_q(chr_addr)
  );

endmodule

// File: rtl/chr_bitmap_remap_chk.sv
module chr_bitmap_remap_chk #(
  parameter int PPU_W = 14
) (
  input logic             clk,
  input logic             rst,
  input logic [PPU_W-1:0] ppu_addr,
  input logic             bitmap_en,
  input logic [PPU_W-2:0] chr_addr,
  input logic             rise,
  input logic             lat_lo,
  input logic             lat_hi,
  input logic [PPU_W-1:0] samp_addr
);

  logic [1:0] warm;
  logic       ok;

  always_ff @(posedge clk) begin
    if (rst)            warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;
  end

  always_comb ok = (warm >= 2'd2);

  AST_RESET_CLEAR: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> chr_addr == '0); // R1

  AST_OFF_PASS: assert property (@(posedge clk) disable iff (rst)
    (ok && !$past(bitmap_en, 2)) |-> chr_addr == $past(ppu_addr[PPU_W-2:0], 2)); // R2

  AST_NT_PASS: assert property (@(posedge clk) disable iff (rst)
    (ok && $past(ppu_addr[PPU_W-1], 2)) |-> chr_addr == $past(ppu_addr[PPU_W-2:0], 2)); // R3

  AST_REMAP_BITS: assert property (@(posedge clk) disable iff (rst)
    (ok && $past(bitmap_en, 2) && !$past(ppu_addr[PPU_W-1], 2))
      |-> (chr_addr[3] == $past(lat_lo) && chr_addr[12] == $past(lat_hi))); // R4

  AST_LATCH_HOLD: assert property (@(posedge clk) disable iff (rst)
    !rise |=> ($stable(lat_lo) && $stable(lat_hi))); // R5

  AST_LATCH_LOAD: assert property (@(posedge clk) disable iff (rst)
    rise |=> (lat_lo == $past(samp_addr[0]) && lat_hi == $past(samp_addr[9]))); // R10

  AST_RISE_ONCE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R10

  AST_LOW_BITS: assert property (@(posedge clk) disable iff (rst)
    ok |-> (chr_addr[2:0] == $past(ppu_addr[2:0], 2)
            && chr_addr[11:4] == $past(ppu_addr[11:4], 2))); // R6

endmodule

bind chr_bitmap_remap chr_bitmap_remap_chk #(.PPU_W(PPU_W)) u_chk (
  .clk(clk), .rst(rst), .ppu_addr(ppu_addr), .bitmap_en(bitmap_en),
  .chr_addr(chr_addr), .rise(a13_rise), .lat_lo(lat_lo), .lat_hi(lat_hi),
  .samp_addr(samp_addr)
);

// File: tb/chr_bitmap_remap_bench.sv
module chr_bitmap_remap_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] ppu_addr = '0;
  logic        bitmap_en = 1'b0;
  logic [12:0] chr_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  chr_bitmap_remap u_chr_bitmap_remap (
    .clk(clk), .rst(rst), .ppu_addr(ppu_addr),
    .bitmap_en(bitmap_en), .chr_addr(chr_addr)
  );

  // Behavioural reference model
  logic [13:0] m_s = '0;
  logic        m_en = 1'b0;
  logic        m_prev = 1'b0;
  logic        m_lo = 1'b0, m_hi = 1'b0;
  logic [12:0] m_exp = '0;
  string       m_tag = "R1";
  bit          m_valid = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_exp = '0; m_lo = 0; m_hi = 0; m_prev = 0; m_tag = "R1";
    end else begin
      m_exp = m_s[12:0];
      if (m_en && !m_s[13]) begin
        m_exp[3] = m_lo; m_exp[12] = m_hi; m_tag = "R4";
      end else begin
        m_tag = m_s[13] ? "R3" : "R2";
      end
      if (m_s[13] && !m_prev) begin m_lo = m_s[0]; m_hi = m_s[9]; end
      m_prev = m_s[13];
    end
    m_s  = rst ? 14'h0 : ppu_addr;
    m_en = rst ? 1'b0 : bitmap_en;
    m_valid = 1;
  end

  task automatic check(string tag, logic [12:0] act, logic [12:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (m_valid && !finished) check({m_tag, " model"}, chr_addr, m_exp);
  end

  task automatic drive(logic [13:0] a, logic e);
    @(negedge clk);
    ppu_addr = a; bitmap_en = e;
  endtask

  task automatic probe(logic [13:0] a, logic e, logic [12:0] exp, string tag);
    drive(a, e);
    @(negedge clk);
    @(negedge clk);
    check(tag, chr_addr, exp);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    ppu_addr = 14'h1ABC; bitmap_en = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 in reset", chr_addr, 13'h0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", chr_addr, 13'h0);
    // R7: no name-table access yet, captured pair still 0
    drive(14'h0000, 1'b1);
    probe(14'h1FFF, 1'b1, 13'h0FF7, "R7");
    // R10: capture with mode off; R3 name-table passthrough
    probe(14'h2201, 1'b0, 13'h0201, "R3");
    probe(14'h0000, 1'b1, 13'h1008, "R10");
    probe(14'h0A50, 1'b1, 13'h1A58, "R5 hold across pattern reads");
    probe(14'h0555, 1'b1, 13'h155D, "R6");
    // R5: new rise loads 0,0; A13 held high with address change must not reload
    probe(14'h2000, 1'b1, 13'h0000, "R3");
    probe(14'h2201, 1'b1, 13'h0201, "R3");
    probe(14'h1FFF, 1'b1, 13'h0FF7, "R5 no reload while A13 high");
    // R2/R9: mode off passes through
    probe(14'h1FFF, 1'b0, 13'h1FFF, "R9");
    probe(14'h0A5A, 1'b0, 13'h0A5A, "R2");
    // R8 latency: output unchanged after one edge
    drive(14'h0123, 1'b0);
    @(negedge clk);
    check("R8 one edge", chr_addr, 13'h0A5A);
    @(negedge clk);
    check("R8 two edges", chr_addr, 13'h0123);
    // Collision: one-cycle name-table sample then immediate pattern read
    drive(14'h2201, 1'b1);
    drive(14'h0000, 1'b1);
    @(negedge clk);
    check("R3 collision nt", chr_addr, 13'h0201);
    @(negedge clk);
    check("R5 collision new capture", chr_addr, 13'h1008);
    // R9: enable toggled every cycle on a fixed pattern address
    for (int i = 0; i < 16; i++) drive(14'h0800, i[0]);
    // Mixed traffic compared by the model each cycle
    for (int i = 0; i < 600; i++) begin
      logic [13:0] a;
      a = 14'($urandom);
      if ((i % 5) != 0) a[13] = 1'b0;
      drive(a, 1'($urandom));
    end
    // Reset in mid-run clears the captured pair (R7)
    drive(14'h2201, 1'b1);
    drive(14'h0000, 1'b1);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check("R1 reset again", chr_addr, 13'h0);
    rst = 1'b0;
    probe(14'h0000, 1'b1, 13'h0000, "R7 after reset");
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule